// File: doc/BRIEF.md
# Flash Erase-Block Lock Manager

This block keeps one write-protection state for every erase block of a flash array. The three states are unlocked, locked and lock-tight, and each is held one-hot. A host loads a first-block index and a last-block index into two range registers, then issues one of four opcodes. The block walks the selected blocks one per clock and rewrites their states under the rules of that opcode. Every state it writes is mirrored into a write-protect status word. When the walk ends, the block pulses `done`, raises an interrupt flag, and sets a sticky error flag if the walk ran past the last real block. Erase and program engines ask whether a block may be written through a combinational query port.

The controller has three states. IDLE waits for a command. WALK visits one block per clock. FINISH lasts one cycle, drives `done` and then returns to IDLE. The transitions are:
- accept: IDLE to WALK, on a known opcode with a non-empty range.
- empty: IDLE to FINISH, on a known opcode whose first index is above its last.
- step: WALK to WALK, after a block is handled and the last index has not been reached.
- last: WALK to FINISH, after the last index is handled.
- abort: WALK to FINISH, when a lock or unlock walk meets a lock-tight block.
- overrun: WALK to FINISH, when the index reaches the block count; this also sets the error flag.
- retire: FINISH to IDLE.

Top module: `flash_lock_mgr`

## Requirements
- R1: After reset every block is locked, so the query reports no block writable. The status word is 0x0002, and `busy`, `done`, `irq` and `cmd_err` are all 0. State encodings are lock-tight = 3'b001, locked = 3'b010 and unlocked = 3'b100.
- R2: A write to the first-index register loads the value into both the first and last registers. A write to the last-index register changes only the last register.
- R3: Opcode 8'h23 sets unlocked and opcode 8'h2A sets locked on blocks first..last inclusive, in ascending order. Either walk stops, without writing, at the first lock-tight block.
- R4: Opcode 8'h27 sets unlocked on blocks from 0 up to NUM_BLOCKS-1 and stops at the first lock-tight block.
- R5: Opcode 8'h2C sets lock-tight on every block in first..last that is not unlocked. Unlocked blocks are skipped and the walk continues past them.
- R6: If a walk reaches an index at or above NUM_BLOCKS, it stops there and sets `cmd_err`. The flag holds until `irq_ack`.
- R7: Each block write copies the new 3-bit state, zero-extended, into the 16-bit status word. When a walk ends, `irq` rises, one cycle after `done`, and holds until `irq_ack`.
- R8: `busy` is high from the cycle after a command is accepted until the walk ends. A command presented while `busy` is high is ignored.
- R9: `done` is a single-cycle pulse in the cycle after the last block is handled. For a walk of n blocks with no abort, it is high n+1 cycles after the accepting edge. For an empty range it is high one cycle after that edge.
- R10: An opcode other than the four above starts nothing and changes no state, status or flag.
- R11: `query_writable` is 1 only for an index below NUM_BLOCKS whose block is unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset |
| first_we | input | 1 | Write strobe for the first-index register (also loads the last index) |
| last_we | input | 1 | Write strobe for the last-index register |
| range_wdata | input | IDX_W | Block index written by either strobe |
| cmd_valid | input | 1 | Command strobe |
| cmd_opcode | input | 8 | Command opcode |
| irq_ack | input | 1 | Clears `irq` and `cmd_err` |
| query_blk | input | IDX_W | Block index to test |
| query_writable | output | 1 | Queried block may be written |
| first_idx | output | IDX_W | First-index register |
| last_idx | output | IDX_W | Last-index register |
| wp_status | output | 16 | Last state written, zero-extended |
| busy | output | 1 | Walk in progress |
| done | output | 1 | End-of-walk pulse |
| irq | output | 1 | Command-complete flag |
| cmd_err | output | 1 | Walk overran the block count |

## Verification
Directed sequences build tables that mix all three states. They then show how the two walk families differ: lock and unlock walks abort at a lock-tight block, while lock-tight walks only skip unlocked blocks. A range that runs past the block count tells an overrun error apart from an abort, and an empty range tells the early-finish path apart from a one-block walk. Random opcodes, ranges and acknowledges from a fixed seed are compared against a bench model of the table. This covers every writable and non-writable block, the status word, and the interrupt and error flags, and it includes commands pushed while busy and unknown opcodes.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
    typedef enum logic [2:0] {
        BLK_TIGHT    = 3'b001,
        BLK_LOCKED   = 3'b010,
        BLK_UNLOCKED = 3'b100
    } blk_state_e;

    typedef enum logic [1:0] {
        OP_UNLOCK_RANGE,
        OP_LOCK_RANGE,
        OP_UNLOCK_ALL,
        OP_TIGHTEN_RANGE
    } walk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WALK,
        ST_FINISH
    } walk_fsm_e;

    localparam logic [7:0] OPC_UNLOCK_RANGE = 8'h23;
    localparam logic [7:0] OPC_UNLOCK_ALL   = 8'h27;
    localparam logic [7:0] OPC_LOCK_RANGE   = 8'h2A;
    localparam logic [7:0] OPC_TIGHTEN      = 8'h2C;
endpackage

// File: rtl/lock_range_regs.sv
module lock_range_regs #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_we,
    input  logic             last_we,
    input  logic [IDX_W-1:0] wdata,
    output logic [IDX_W-1:0] first_q,
    output logic [IDX_W-1:0] last_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= '0;
            last_q  <= '0;
        end else begin
            if (first_we) begin
                first_q <= wdata;
                last_q  <= wdata;
            end else if (last_we) begin
                last_q  <= wdata;
            end
        end
    end

    // R2: first-index write mirrors into last index
    a_r2_first_sets_last: assert property (@(posedge clk) disable iff (!rst_n)
        first_we |=> (last_q == first_q));
endmodule

// File: rtl/lock_state_table.sv
module lock_state_table
    import flash_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  blk_state_e       wr_state,
    input  logic [IDX_W-1:0] rd_idx,
    output blk_state_e       rd_state,
    input  logic [IDX_W-1:0] q_idx,
    output logic             q_writable
);
    localparam int SLOTS = 1 << IDX_W;

    logic [2:0] cell_q [SLOTS];

    for (genvar b = 0; b < SLOTS; b++) begin : g_cell
        if (b < NUM_BLOCKS) begin : g_real
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cell_q[b] <= BLK_LOCKED;
                end else if (wr_en && (wr_idx == IDX_W'(b))) begin
                    cell_q[b] <= wr_state;
                end
            end
        end else begin : g_absent
            assign cell_q[b] = 3'b000;
        end
    end

    assign rd_state   = blk_state_e'(cell_q[rd_idx]);
    assign q_writable = (cell_q[q_idx] == BLK_UNLOCKED);

    // R1: every real block holds exactly one state bit
    a_r1_onehot_state: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_idx} < (IDX_W+1)'(NUM_BLOCKS)) |-> ($countones(cell_q[rd_idx]) == 1));

    // R5: a lock-tight block is only ever rewritten as lock-tight
    a_r5_tight_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == rd_idx) && (rd_state == BLK_TIGHT)) |-> (wr_state == BLK_TIGHT));
endmodule

// File: rtl/lock_walker.sv
module lock_walker
    import flash_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_opcode,
    input  logic [IDX_W-1:0] first_idx,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] rd_idx,
    input  blk_state_e       rd_state,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output blk_state_e       wr_state,
    output logic             err_set,
    output logic             fin_set,
    output logic             busy,
    output logic             done
);
    localparam logic [IDX_W:0]   BLK_LIMIT = (IDX_W+1)'(NUM_BLOCKS);
    localparam logic [IDX_W-1:0] TOP_IDX   = IDX_W'(NUM_BLOCKS - 1);

    walk_fsm_e        state_q, state_d;
    walk_op_e         op_q, op_d;
    logic [IDX_W-1:0] cur_q, cur_d;
    logic [IDX_W-1:0] end_q, end_d;

    logic             known_op;
    walk_op_e         dec_op;
    logic [IDX_W-1:0] start_sel, end_sel;
    logic             out_of_range, hit_tight, hit_unlocked;

    always_comb begin
        known_op = 1'b1;
        dec_op   = OP_UNLOCK_RANGE;
        unique case (cmd_opcode)
            OPC_UNLOCK_RANGE: dec_op = OP_UNLOCK_RANGE;
            OPC_LOCK_RANGE:   dec_op = OP_LOCK_RANGE;
            OPC_UNLOCK_ALL:   dec_op = OP_UNLOCK_ALL;
            OPC_TIGHTEN:      dec_op = OP_TIGHTEN_RANGE;
            default:          known_op = 1'b0;
        endcase
    end

    assign start_sel    = (dec_op == OP_UNLOCK_ALL) ? '0 : first_idx;
    assign end_sel      = (dec_op == OP_UNLOCK_ALL) ? TOP_IDX : last_idx;
    assign out_of_range = ({1'b0, cur_q} >= BLK_LIMIT);
    assign hit_tight    = (rd_state == BLK_TIGHT);
    assign hit_unlocked = (rd_state == BLK_UNLOCKED);
    assign rd_idx       = cur_q;
    assign wr_idx       = cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_UNLOCK_RANGE;
            cur_q   <= '0;
            end_q   <= '0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            cur_q   <= cur_d;
            end_q   <= end_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        op_d     = op_q;
        cur_d    = cur_q;
        end_d    = end_q;
        wr_en    = 1'b0;
        wr_state = BLK_LOCKED;
        err_set  = 1'b0;
        fin_set  = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid && known_op) begin
                    op_d  = dec_op;
                    cur_d = start_sel;
                    end_d = end_sel;
                    if (start_sel > end_sel) begin
                        state_d = ST_FINISH;
                    end else begin
                        state_d = ST_WALK;
                    end
                end
            end
            ST_WALK: begin
                busy = 1'b1;
                if (out_of_range) begin
                    err_set = 1'b1;
                    state_d = ST_FINISH;
                end else if ((op_q != OP_TIGHTEN_RANGE) && hit_tight) begin
                    state_d = ST_FINISH;
                end else begin
                    unique case (op_q)
                        OP_UNLOCK_RANGE, OP_UNLOCK_ALL: begin
                            wr_en    = 1'b1;
                            wr_state = BLK_UNLOCKED;
                        end
                        OP_LOCK_RANGE: begin
                            wr_en    = 1'b1;
                            wr_state = BLK_LOCKED;
                        end
                        OP_TIGHTEN_RANGE: begin
                            wr_en    = !hit_unlocked;
                            wr_state = BLK_TIGHT;
                        end
                        default: ;
                    endcase
                    if (cur_q == end_q) begin
                        state_d = ST_FINISH;
                    end else begin
                        cur_d = cur_q + 1'b1;
                    end
                end
            end
            ST_FINISH: begin
                busy    = 1'b1;
                done    = 1'b1;
                fin_set = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R9: done lasts a single cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the walk target stays frozen while busy, whatever the command pins do
    a_r8_end_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(end_q));

    // R3: lock and unlock walks never write a lock-tight block
    a_r3_no_tight_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (op_q != OP_TIGHTEN_RANGE)) |-> !hit_tight);

    // R6: an error is only raised at an index beyond the table
    a_r6_err_oob: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |-> ({1'b0, rd_idx} >= BLK_LIMIT));
endmodule

// File: rtl/lock_status.sv
module lock_status
    import flash_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  blk_state_e  wr_state,
    input  logic        err_set,
    input  logic        fin_set,
    input  logic        ack,
    output logic [15:0] wp_status,
    output logic        irq,
    output logic        cmd_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_status <= 16'h0002;
            irq       <= 1'b0;
            cmd_err   <= 1'b0;
        end else begin
            if (wr_en) begin
                wp_status <= {13'd0, wr_state};
            end
            if (fin_set) begin
                irq <= 1'b1;
            end else if (ack) begin
                irq <= 1'b0;
            end
            if (err_set) begin
                cmd_err <= 1'b1;
            end else if (ack) begin
                cmd_err <= 1'b0;
            end
        end
    end

    // R7: the interrupt only rises at the end of a walk
    a_r7_irq_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(fin_set));

    // R7: status word always holds a one-hot state
    a_r7_wp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(wp_status) == 1) && (wp_status[15:3] == 13'd0));
endmodule

// File: rtl/flash_lock_mgr.sv
module flash_lock_mgr
    import flash_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int IDX_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_we,
    input  logic             last_we,
    input  logic [IDX_W-1:0] range_wdata,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_opcode,
    input  logic             irq_ack,
    input  logic [IDX_W-1:0] query_blk,
    output logic             query_writable,
    output logic [IDX_W-1:0] first_idx,
    output logic [IDX_W-1:0] last_idx,
    output logic [15:0]      wp_status,
    output logic             busy,
    output logic             done,
    output logic             irq,
    output logic             cmd_err
);
    logic [IDX_W-1:0] rd_idx, wr_idx;
    blk_state_e       rd_state, wr_state;
    logic             wr_en, err_set, fin_set;

    lock_range_regs #(.IDX_W(IDX_W)) u_range (
        .clk     (clk),
        .rst_n   (rst_n),
        .first_we(first_we),
        .last_we (last_we),
        .wdata   (range_wdata),
        .first_q (first_idx),
        .last_q  (last_idx)
    );

    lock_state_table #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_state  (wr_state),
        .rd_idx    (rd_idx),
        .rd_state  (rd_state),
        .q_idx     (query_blk),
        .q_writable(query_writable)
    );

    lock_walker #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_opcode(cmd_opcode),
        .first_idx (first_idx),
        .last_idx  (last_idx),
        .rd_idx    (rd_idx),
        .rd_state  (rd_state),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_state  (wr_state),
        .err_set   (err_set),
        .fin_set   (fin_set),
        .busy      (busy),
        .done      (done)
    );

    lock_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_state (wr_state),
        .err_set  (err_set),
        .fin_set  (fin_set),
        .ack      (irq_ack),
        .wp_status(wp_status),
        .irq      (irq),
        .cmd_err  (cmd_err)
    );

    // R6: the error flag rises together with the done pulse
    a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_err) |-> done);
endmodule

// File: tb/tb_flash_lock_mgr.sv
module tb_flash_lock_mgr;
    localparam int N     = 12;
    localparam int IW    = 4;
    localparam int SLOTS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          first_we = 1'b0, last_we = 1'b0;
    logic [IW-1:0] range_wdata = '0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_opcode = '0;
    logic          irq_ack = 1'b0;
    logic [IW-1:0] query_blk = '0;
    logic          query_writable;
    logic [IW-1:0] first_idx, last_idx;
    logic [15:0]   wp_status;
    logic          busy, done, irq, cmd_err;

    flash_lock_mgr #(.NUM_BLOCKS(N)) dut (
        .clk(clk), .rst_n(rst_n), .first_we(first_we), .last_we(last_we),
        .range_wdata(range_wdata), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .irq_ack(irq_ack), .query_blk(query_blk), .query_writable(query_writable),
        .first_idx(first_idx), .last_idx(last_idx), .wp_status(wp_status),
        .busy(busy), .done(done), .irq(irq), .cmd_err(cmd_err)
    );

    always #4 clk = ~clk;

    int total = 0, bad = 0, cycles = 0;
    int mdl[SLOTS];
    int m_first = 0, m_last = 0, m_wp = 2, m_irq = 0, m_err = 0;

    always @(posedge clk) cycles++;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < SLOTS; i++) mdl[i] = (i < N) ? 2 : 0;
        m_first = 0; m_last = 0; m_wp = 2; m_irq = 0; m_err = 0;
    endfunction

    // returns number of blocks visited and whether the walk aborted
    function automatic int model_cmd(input logic [7:0] op, output bit early);
        int s, e, n;
        early = 0; n = 0;
        s = (op == 8'h27) ? 0 : m_first;
        e = (op == 8'h27) ? N - 1 : m_last;
        m_irq = 1;
        for (int b = s; b <= e; b++) begin
            n++;
            if (b >= N) begin m_err = 1; early = 1; return n; end
            if (op == 8'h2C) begin
                if (mdl[b] != 4) begin mdl[b] = 1; m_wp = 1; end
            end else begin
                if (mdl[b] == 1) begin early = 1; return n; end
                mdl[b] = (op == 8'h2A) ? 2 : 4;
                m_wp = mdl[b];
            end
        end
        return n;
    endfunction

    task automatic wr_first(input int v);
        @(negedge clk); first_we = 1; range_wdata = IW'(v);
        @(negedge clk); first_we = 0;
        m_first = v; m_last = v;
    endtask

    task automatic wr_last(input int v);
        @(negedge clk); last_we = 1; range_wdata = IW'(v);
        @(negedge clk); last_we = 0;
        m_last = v;
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < SLOTS; i++) begin
            query_blk = IW'(i); #1;
            chk(req, int'(query_writable), (mdl[i] == 4) ? 1 : 0);
        end
        chk("R7 wp", int'(wp_status), m_wp);
        chk("R7 irq", int'(irq), m_irq);
        chk("R6 err", int'(cmd_err), m_err);
    endtask

    // issue a command and return the negedge count at which done was seen
    task automatic run_cmd(input logic [7:0] op, output int lat);
        bit known;
        known = (op == 8'h23) || (op == 8'h27) || (op == 8'h2A) || (op == 8'h2C);
        @(negedge clk); cmd_valid = 1; cmd_opcode = op;
        @(negedge clk); cmd_valid = 0; lat = 1;
        if (known) begin
            while (!done && cycles < 150000) begin @(negedge clk); lat++; end
            @(negedge clk);
            chk("R9 done single", int'(done), 0);
            chk("R8 busy clear", int'(busy), 0);
        end else begin
            repeat (3) begin
                chk("R10 no start", int'(busy | done), 0);
                @(negedge clk);
            end
        end
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
        m_irq = 0; m_err = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; model_reset();
        @(negedge clk);
    endtask

    initial begin : watchdog
        wait (cycles > 160000);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<160000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        bit early;
        int n;
        void'($urandom(32'd2024));
        do_reset();
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        check_all("R1 locked at reset");
        // R2
        wr_first(3);
        chk("R2 first", int'(first_idx), 3);
        chk("R2 last mirrors", int'(last_idx), 3);
        wr_last(7);
        chk("R2 last only", int'(last_idx), 7);
        chk("R2 first kept", int'(first_idx), 3);
        // R3 unlock 3..7, R9 latency 5 blocks + 1
        n = model_cmd(8'h23, early);
        run_cmd(8'h23, lat);
        chk("R9 latency", lat, n + 1);
        check_all("R3 unlock range");
        ack();
        chk("R7 irq cleared", int'(irq), 0);
        // R5 tighten 2..9
        wr_first(2); wr_last(9);
        n = model_cmd(8'h2C, early); run_cmd(8'h2C, lat);
        check_all("R5 tighten skips unlocked");
        // R3 unlock 0..11 aborts at block 2
        wr_first(0); wr_last(11);
        n = model_cmd(8'h23, early); run_cmd(8'h23, lat);
        chk("R3 abort latency", lat, n + 1);
        check_all("R3 unlock stops at tight");
        // R3 lock 4..11 stops at 8
        wr_first(4); wr_last(11);
        n = model_cmd(8'h2A, early); run_cmd(8'h2A, lat);
        check_all("R3 lock stops at tight");
        // R4 unlock-all stops at 2
        n = model_cmd(8'h27, early); run_cmd(8'h27, lat);
        check_all("R4 unlock all");
        ack();
        // R6 overrun 10..14
        wr_first(10); wr_last(14);
        n = model_cmd(8'h2A, early); run_cmd(8'h2A, lat);
        chk("R6 overrun latency", lat, n + 1);
        check_all("R6 overrun error");
        ack();
        chk("R6 err cleared", int'(cmd_err), 0);
        // R9 empty range
        wr_first(5); wr_last(2);
        n = model_cmd(8'h23, early); run_cmd(8'h23, lat);
        chk("R9 empty latency", lat, 1);
        check_all("R9 empty range no change");
        // R10 unknown opcode
        run_cmd(8'h55, lat);
        check_all("R10 unknown opcode");
        // R8 command while busy ignored
        do_reset();
        @(negedge clk); cmd_valid = 1; cmd_opcode = 8'h27;
        @(negedge clk); cmd_opcode = 8'h2C; wr_first(0); wr_last(11);
        @(negedge clk); cmd_valid = 1; cmd_opcode = 8'h2C;
        chk("R8 busy high", int'(busy), 1);
        @(negedge clk); cmd_valid = 0;
        while (!done && cycles < 150000) @(negedge clk);
        @(negedge clk);
        n = model_cmd(8'h27, early);
        check_all("R8 busy ignores command");
        ack();
        // random phase
        for (int it = 0; it < 80; it++) begin
            int r, opsel;
            logic [7:0] op;
            r = $urandom_range(0, 2);
            if (r == 0) wr_first($urandom_range(0, 15));
            else if (r == 1) begin wr_first($urandom_range(0, 15)); wr_last($urandom_range(0, 15)); end
            opsel = $urandom_range(0, 9);
            case (opsel)
                0, 1: op = 8'h23;
                2, 3: op = 8'h2A;
                4:    op = 8'h27;
                5, 6, 7: op = 8'h2C;
                default: op = 8'(($urandom_range(0, 255) & 8'hF0) | 8'h01);
            endcase
            if ((op == 8'h23) || (op == 8'h27) || (op == 8'h2A) || (op == 8'h2C))
                n = model_cmd(op, early);
            run_cmd(op, lat);
            check_all("R11 random table");
            if ($urandom_range(0, 3) == 0) ack();
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule